// File: doc/BRIEF.md
# Host Interrupt Request Generator

This block lets a slave processor raise five level interrupt requests toward a master host, and it holds the four byte-wide data registers that the host collects. The slave sees one control register. Each of its five low bits drives one request line. A line goes high only through a deliberate handshake: the slave first reads the control register while that line's bit is 0, and then writes a 1 to that bit. A stray write of 1 does nothing.

The host never touches the control register. When it reads one of the four data registers, the request lines tied to that register drop on their own. The slave can also drop a line at any time by writing a 0 to its bit. The normal flow has four steps. The slave loads a byte into a data register and raises the matching line. The host reads the byte, and that read lowers the line. The slave polls the bit until it reads 0, then sends the next byte.

Slave address map: address 0 is the control register (bits [4:0] are lines 0 to 4). Addresses 1 to 4 are data registers 1 to 4. Addresses 5 to 7 are unused. On the host side, the select values 0 to 3 pick data registers 1 to 4.

Top module: `host_irq_gen`

## Requirements
- R1: After reset, all five request outputs are 0, the control register reads 0 and every data register reads 0 from both sides.
- R2: When the slave reads address 0 while bit i is 0, and its next write to address 0 has bit i at 1, line i goes high at the clock edge of that write. The line is visible on `hostIrq` in the following cycle.
- R3: A write of 1 to a control bit has no effect on a line that is low when the write is not preceded by a qualifying read of 0. Every write to address 0 consumes all pending read-of-0 qualifications, so a second write of 1 needs a fresh read.
- R4: A slave write to address 0 with bit i at 0 forces line i low at that edge. This holds regardless of any pending qualification.
- R5: A host read with select 0 (data register 1) clears lines 1 and 2. Select 1 (data register 2) clears line 0. Select 2 (data register 3) clears line 3. Select 3 (data register 4) clears line 4. No other line changes.
- R6: If a host read that clears line i falls in the same cycle as a qualified slave write of 1 to bit i, the line ends low.
- R7: A slave write to address k (1 to 4) stores the byte in data register k. That value is returned by a host read with select k-1 and by a slave read of address k, until the next write to that address.
- R8: A slave read of address 0 returns the five line states in bits [4:0] with the upper bits 0. Reads of addresses 5 to 7 return 0, and writes to them change no register.
- R9: When the slave asserts read and write in the same cycle, the write acts with the qualifications gathered before that cycle, and the read qualifies no bit.
- R10: A line that is already high stays high on a slave write of 1 to its bit, qualified or not, unless a host clear hits it in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| slvRd | input | 1 | Slave read strobe |
| slvWr | input | 1 | Slave write strobe |
| slvAddr | input | 3 | Slave register address |
| slvWdata | input | 8 | Slave write data |
| slvRdata | output | 8 | Slave read data, combinational from address |
| hostRd | input | 1 | Host read strobe for the data registers |
| hostSel | input | 2 | Host data register select (0 to 3 for registers 1 to 4) |
| hostRdata | output | 8 | Host read data, combinational from select |
| hostIrq | output | 5 | Request lines, active high, registered |

## Verification
Directed sequences come first. They cover the raise handshake, a write of 1 with no read before it, a write of 0 that clears, each host select clearing its own lines, and a host clear that collides with a set. Together these separate the set condition from the two clear paths and from the shared-register mapping. A long pseudo-random sweep then mixes control reads, control writes, data-register writes to every address (the unused ones included), host reads, and read-plus-write or write-plus-host-read cycles. Every line and every read data value is compared each cycle with a bench model. The sweep exposes errors in qualification lifetime, priority and address decoding that the short directed cases can miss.

// File: rtl/host_irq_pkg.sv
package host_irq_pkg;
  localparam int NUM_LINES = 5;
  localparam int NUM_ODR   = 4;
  localparam int DATA_W    = 8;
  localparam int ADDR_W    = 3;
  localparam int SEL_W     = $clog2(NUM_ODR);

  typedef struct packed {
    logic                 ctrlWr;
    logic                 ctrlRd;
    logic [NUM_ODR-1:0]   odrWr;
    logic [NUM_LINES-1:0] hostClr;
  } strobe_t;

  // host select index (0 = data register 1) whose read clears a line
  function automatic logic [SEL_W-1:0] selOfLine(input int line);
    case (line)
      0:       return SEL_W'(1);
      1, 2:    return SEL_W'(0);
      3:       return SEL_W'(2);
      default: return SEL_W'(3);
    endcase
  endfunction
endpackage

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import host_irq_pkg::*;
#(
  parameter int ADDR_BITS = ADDR_W,
  parameter int SEL_BITS  = SEL_W
) (
  input  logic                 slvRd,
  input  logic                 slvWr,
  input  logic [ADDR_BITS-1:0] slvAddr,
  input  logic                 hostRd,
  input  logic [SEL_BITS-1:0]  hostSel,
  output strobe_t              stb
);
  logic ctrlHit;
  assign ctrlHit = (slvAddr == '0);

  always_comb begin
    stb.ctrlWr = slvWr & ctrlHit;
    // a write in the same cycle takes precedence; the read arms nothing
    stb.ctrlRd = slvRd & ~slvWr & ctrlHit;
  end

  for (genvar k = 0; k < NUM_ODR; k++) begin : g_odrDec
    assign stb.odrWr[k] = slvWr & (slvAddr == ADDR_BITS'(k + 1));
  end

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_clrDec
    assign stb.hostClr[i] = hostRd & (hostSel == selOfLine(i));
  end
endmodule

// File: rtl/irq_datapath.sv
module irq_datapath
  import host_irq_pkg::*;
#(
  parameter int DW        = DATA_W,
  parameter int ADDR_BITS = ADDR_W,
  parameter int SEL_BITS  = SEL_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              stb,
  input  logic [DW-1:0]        slvWdata,
  input  logic [ADDR_BITS-1:0] slvAddr,
  input  logic [SEL_BITS-1:0]  hostSel,
  output logic [DW-1:0]        slvRdata,
  output logic [DW-1:0]        hostRdata,
  output logic [NUM_LINES-1:0] irqQ
);
  logic [NUM_LINES-1:0] irqD;
  logic [NUM_LINES-1:0] armQ, armD;
  logic [DW-1:0]        odrQ [NUM_ODR];

  always_comb begin
    for (int i = 0; i < NUM_LINES; i++) begin
      irqD[i] = irqQ[i];
      armD[i] = armQ[i];
      if (stb.ctrlWr) begin
        armD[i] = 1'b0;
        if (!slvWdata[i])                          irqD[i] = 1'b0;
        else if (stb.hostClr[i])                   irqD[i] = 1'b0;
        else if (armQ[i])                          irqD[i] = 1'b1;
      end else begin
        if (stb.hostClr[i])                        irqD[i] = 1'b0;
        if (stb.ctrlRd && !irqQ[i])                armD[i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqQ <= '0;
      armQ <= '0;
    end else begin
      irqQ <= irqD;
      armQ <= armD;
    end
  end

  for (genvar k = 0; k < NUM_ODR; k++) begin : g_odr
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)             odrQ[k] <= '0;
      else if (stb.odrWr[k]) odrQ[k] <= slvWdata;
    end
  end

  always_comb begin
    slvRdata = '0;
    if (slvAddr == '0) slvRdata = DW'(irqQ);
    for (int k = 0; k < NUM_ODR; k++)
      if (slvAddr == ADDR_BITS'(k + 1)) slvRdata = odrQ[k];
  end

  assign hostRdata = odrQ[hostSel];
endmodule

// File: rtl/host_irq_gen.sv
module host_irq_gen
  import host_irq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 slvRd,
  input  logic                 slvWr,
  input  logic [ADDR_W-1:0]    slvAddr,
  input  logic [DATA_W-1:0]    slvWdata,
  output logic [DATA_W-1:0]    slvRdata,
  input  logic                 hostRd,
  input  logic [SEL_W-1:0]     hostSel,
  output logic [DATA_W-1:0]    hostRdata,
  output logic [NUM_LINES-1:0] hostIrq
);
  strobe_t stb;

  irq_ctrl u_ctrl (
    .slvRd   (slvRd),
    .slvWr   (slvWr),
    .slvAddr (slvAddr),
    .hostRd  (hostRd),
    .hostSel (hostSel),
    .stb     (stb)
  );

  irq_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .slvWdata  (slvWdata),
    .slvAddr   (slvAddr),
    .hostSel   (hostSel),
    .slvRdata  (slvRdata),
    .hostRdata (hostRdata),
    .irqQ      (hostIrq)
  );
endmodule

// File: rtl/host_irq_gen_chk.sv
module host_irq_gen_chk
  import host_irq_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 slvRd,
  input logic                 slvWr,
  input logic [ADDR_W-1:0]    slvAddr,
  input logic [DATA_W-1:0]    slvWdata,
  input logic [DATA_W-1:0]    slvRdata,
  input logic                 hostRd,
  input logic [SEL_W-1:0]     hostSel,
  input logic [DATA_W-1:0]    hostRdata,
  input logic [NUM_LINES-1:0] hostIrq
);
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    // R2 / R3: a line only rises after a control write of 1 to its bit
    p_rise_needs_write_r2: assert property (@(posedge clk) disable iff (!rstN)
      $rose(hostIrq[i]) |-> $past(slvWr && slvAddr == '0 && slvWdata[i]));

    // R4: a control write of 0 leaves the line low
    p_write0_clears_r4: assert property (@(posedge clk) disable iff (!rstN)
      (slvWr && slvAddr == '0 && !slvWdata[i]) |=> !hostIrq[i]);

    // R5 / R6: a host read of the mapped register leaves the line low
    p_host_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
      (hostRd && hostSel == selOfLine(i)) |=> !hostIrq[i]);
  end

  for (genvar k = 0; k < NUM_ODR; k++) begin : g_odr
    // R7: a stored byte is what the host sees on that select next cycle
    p_odr_readback_r7: assert property (@(posedge clk) disable iff (!rstN)
      (slvWr && slvAddr == ADDR_W'(k + 1)) |=>
        (hostSel != SEL_W'(k) || hostRdata == $past(slvWdata)));
  end

  // R8: control reads carry the lines in the low bits and zero above
  p_ctrl_read_r8: assert property (@(posedge clk) disable iff (!rstN)
    (slvAddr == '0) |-> (slvRdata == DATA_W'(hostIrq)));

  // R8: unused addresses read as zero
  p_unused_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    (slvAddr > ADDR_W'(NUM_ODR)) |-> (slvRdata == '0));
endmodule

bind host_irq_gen host_irq_gen_chk u_chk (.*);

// File: tb/sim_host_irq_gen.sv
`timescale 1ns/1ps
module sim_host_irq_gen;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       slvRd = 1'b0, slvWr = 1'b0, hostRd = 1'b0;
  logic [2:0] slvAddr = '0;
  logic [7:0] slvWdata = '0;
  logic [1:0] hostSel = '0;
  logic [7:0] slvRdata, hostRdata;
  logic [4:0] hostIrq;

  int checks = 0, failures = 0;
  int cycles = 0;

  // bench model
  logic [4:0] mIrq = '0, mArm = '0;
  logic [7:0] mOdr [4];
  logic [31:0] seed = 32'h1234_5678;

  always #5 clk = ~clk;

  host_irq_gen u0 (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] expRd(input logic [2:0] a);
    if (a == 3'd0) return {3'b000, mIrq};
    if (a >= 3'd1 && a <= 3'd4) return mOdr[a-1];
    return 8'h00;
  endfunction

  function automatic logic [4:0] clrMask(input logic h, input logic [1:0] s);
    if (!h) return 5'b0;
    case (s)
      2'd0: return 5'b00110; // R5: register 1 -> lines 1,2
      2'd1: return 5'b00001; // R5: register 2 -> line 0
      2'd2: return 5'b01000; // R5: register 3 -> line 3
      default: return 5'b10000; // R5: register 4 -> line 4
    endcase
  endfunction

  task automatic op(input string tag, input logic rd, input logic wr, input logic [2:0] a,
                    input logic [7:0] wd, input logic h, input logic [1:0] s);
    logic [4:0] hc;
    logic [4:0] nIrq, nArm;
    @(negedge clk);
    slvRd = rd; slvWr = wr; slvAddr = a; slvWdata = wd; hostRd = h; hostSel = s;
    #1;
    chk({tag, " R8 slave read"}, slvRdata, expRd(a));
    chk({tag, " R7 host read"}, hostRdata, mOdr[s]);
    hc = clrMask(h, s);
    nIrq = mIrq; nArm = mArm;
    for (int i = 0; i < 5; i++) begin
      if (wr && a == 3'd0) begin
        nArm[i] = 1'b0;
        if (!wd[i])        nIrq[i] = 1'b0;
        else if (hc[i])    nIrq[i] = 1'b0;
        else if (mArm[i])  nIrq[i] = 1'b1;
      end else begin
        if (hc[i]) nIrq[i] = 1'b0;
        if (rd && a == 3'd0 && !mIrq[i]) nArm[i] = 1'b1;
      end
    end
    @(posedge clk);
    mIrq = nIrq; mArm = nArm;
    if (wr && a >= 3'd1 && a <= 3'd4) mOdr[a-1] = wd;
    #1;
    slvRd = 1'b0; slvWr = 1'b0; hostRd = 1'b0;
    #3;
    chk({tag, " lines"}, hostIrq, mIrq);
  endtask

  initial begin
    for (int k = 0; k < 4; k++) mOdr[k] = '0;
    #23 rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 lines", hostIrq, 5'b0);
    for (int s = 0; s < 4; s++) begin
      hostSel = 2'(s); #1; chk("R1 host data", hostRdata, 8'h00);
    end
    for (int a = 0; a < 8; a++) begin
      slvAddr = 3'(a); #1; chk("R1 slave data", slvRdata, 8'h00);
    end
    // R3 write 1 with no read before it
    op("R3 unqualified", 0, 1, 0, 8'h1F, 0, 0);
    chk("R3 stays low", hostIrq, 5'b0);
    // R2 handshake
    op("R2 read0", 1, 0, 0, 8'h00, 0, 0);
    op("R2 write1", 0, 1, 0, 8'h1F, 0, 0);
    chk("R2 all high", hostIrq, 5'h1F);
    // R10 write 1 while high, not qualified
    op("R10 hold", 0, 1, 0, 8'h1F, 0, 0);
    chk("R10 still high", hostIrq, 5'h1F);
    // R5 each select in turn
    op("R5 sel0", 0, 0, 0, 8'h00, 1, 0);
    chk("R5 sel0 clears 1,2", hostIrq, 5'b11001);
    op("R5 sel1", 0, 0, 0, 8'h00, 1, 1);
    chk("R5 sel1 clears 0", hostIrq, 5'b11000);
    op("R5 sel2", 0, 0, 0, 8'h00, 1, 2);
    chk("R5 sel2 clears 3", hostIrq, 5'b10000);
    op("R5 sel3", 0, 0, 0, 8'h00, 1, 3);
    chk("R5 sel3 clears 4", hostIrq, 5'b00000);
    // R3 qualification consumed by an intervening write
    op("R3 read0", 1, 0, 0, 8'h00, 0, 0);
    op("R3 consume", 0, 1, 0, 8'h00, 0, 0);
    op("R3 late1", 0, 1, 0, 8'h1F, 0, 0);
    chk("R3 consumed", hostIrq, 5'b0);
    // R4 write 0 clears
    op("R4 read0", 1, 0, 0, 8'h00, 0, 0);
    op("R4 set", 0, 1, 0, 8'h1F, 0, 0);
    op("R4 clear0", 0, 1, 0, 8'h1E, 0, 0);
    chk("R4 bit0 low", hostIrq, 5'h1E);
    // R6 host clear collides with set
    op("R6 clr", 0, 1, 0, 8'h00, 0, 0);
    op("R6 read0", 1, 0, 0, 8'h00, 0, 0);
    op("R6 collide", 0, 1, 0, 8'h1F, 1, 0);
    chk("R6 clear wins", hostIrq, 5'b11001);
    // R9 read and write together arm nothing
    op("R9 clr", 0, 1, 0, 8'h00, 0, 0);
    op("R9 both", 1, 1, 0, 8'h00, 0, 0);
    op("R9 write1", 0, 1, 0, 8'h1F, 0, 0);
    chk("R9 no arm", hostIrq, 5'b0);
    // R7 / R8 data registers and unused addresses
    for (int a = 1; a < 8; a++) op("R7 R8 odr write", 0, 1, 3'(a), 8'(a * 37 + 5), 0, 0);
    for (int a = 1; a < 8; a++) op("R7 R8 odr read", 1, 0, 3'(a), 8'h00, 1, 2'((a - 1) % 4));
    // sweep
    for (int n = 0; n < 6000; n++) begin
      seed = seed ^ (seed << 13); seed = seed ^ (seed >> 17); seed = seed ^ (seed << 5);
      case (seed[2:0])
        3'd0, 3'd1: op("sweep R2 ctrl read", 1, 0, 0, 8'h00, seed[8], seed[10:9]);
        3'd2, 3'd3: op("sweep R3 R4 ctrl write", 0, 1, 0, seed[23:16], seed[8], seed[10:9]);
        3'd4:       op("sweep R5 host read", 0, 0, seed[13:11], 8'h00, 1, seed[10:9]);
        3'd5:       op("sweep R7 R8 odr write", 0, 1, seed[13:11], seed[23:16], seed[8], seed[10:9]);
        3'd6:       op("sweep R6 collide", 0, 1, 0, seed[23:16], 1, seed[10:9]);
        default:    op("sweep R9 rd+wr", 1, 1, 0, seed[23:16], seed[8], seed[10:9]);
      endcase
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule